// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous request/acknowledge port and an external asynchronous static RAM of 512K bytes. The memory has a 19-bit address, an 8-bit data path, and three active-low strobes: chip select, write enable and output enable. The host presents one access at a time. The sequencer turns it into a fixed train of clock cycles on the memory pins. Each phase length is worked out at elaboration time from the memory's nanosecond limits and the clock period.

A read holds chip select and output enable low for long enough to cover the address access time, the cycle time and the output-enable access time. The returned byte is captured on the last clock edge of that phase. After a read, a recovery phase keeps the data lines free until the memory has had time to let go of them.

A write is controlled by write enable. The controller drives the byte for the whole time chip select is low. Write enable rises one cycle before chip select, so the memory latches the data on the write-enable edge while the address and data are still held. Between accesses, chip select stays high and the memory sits in standby.

Top module: `sram_ctrl`

## Requirements
- R1: After reset and whenever the sequencer is idle, `sram_cs_n`, `sram_we_n` and `sram_oe_n` are 1, `sram_dq_oe` is 0 and `ack` is 0.
- R2: A read holds `sram_cs_n`=0, `sram_oe_n`=0 and `sram_we_n`=1, with `sram_addr` equal to the request address and `sram_dq_oe`=0, for exactly RD_CYC cycles. RD_CYC is the largest of ceil(55/P), ceil(55/P) and ceil(25/P), with a floor of 1, where P is the clock period in ns. This gives 6 at P=10.
- R3: The byte on `sram_dq_in` in the last read cycle appears on `rdata` while `ack` is 1. `ack` rises RD_CYC cycles after the edge that accepts the read.
- R4: A write holds `sram_we_n`=0 for WR_CYC cycles. WR_CYC is the largest of ceil(35/P), ceil(25/P), ceil(40/P) and ceil(55/P)-1, with a floor of 1, which gives 5 at P=10. `sram_cs_n` stays 0 for WR_CYC+1 cycles, so write enable rises one cycle before chip select. `sram_dq_out` carries the write byte with `sram_dq_oe`=1 throughout that window. `ack` rises WR_CYC+1 cycles after the accepting edge.
- R5: `sram_dq_oe` is 1 only while `sram_oe_n` is 1. Before it rises, `sram_oe_n` has been 1 for at least HZ_CYC = ceil(20/P) cycles, which gives 2 at P=10. The controller and the memory never drive the data lines together.
- R6: `sram_addr` does not change while `sram_cs_n` is 0.
- R7: Only one access runs at a time. `req`, `req_we`, `req_addr` and `req_wdata` are sampled only while idle, and changes to them during an access have no effect. `ack` is high for exactly one cycle per access.
- R8: Every access keeps `sram_cs_n` low for at least ceil(55/P) cycles, so the memory cycle time is met for both reads and writes.
- R9: In the cycle where `ack` is 1, all three strobes are already back at 1 and `sram_dq_oe` is 0, so the memory is in standby.
- R10: A byte written at any address, including 0x00000 and 0x7FFFF, reads back unchanged. Every write gives the memory at least 35 ns of write-enable pulse and 25 ns of data setup, and chip select and the address are held for at least 40 ns before write enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Access request, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address of the access |
| req_wdata | input | 8 | Byte to write |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Read byte, valid while `ack` is 1 after a read |
| sram_addr | output | 19 | Address pins of the memory |
| sram_dq_out | output | 8 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Enable of the controller's data drivers |
| sram_dq_in | input | 8 | Data seen on the memory data lines |
| sram_cs_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |

## Verification
The assertions assume the host keeps `req` and its fields steady from the request until `ack`. They also assume the host withdraws `req` in the cycle where `ack` is seen, so an accepted access is never counted twice. The bench drives all requests on falling clock edges and drops `req` as soon as it samples `ack`. In one scenario it deliberately disturbs the request fields in the middle of an access, to show those changes are ignored. The memory model drives read data only after the address access time and the output-enable access time have elapsed. It keeps the data lines claimed for 20 ns after a read ends. A sequencer that samples too early or turns the bus around too fast therefore shows up as wrong data or as contention.

// File: rtl/sram_ctrl_pkg.sv
`timescale 1ns/1ps
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_RD    = 3'd1,
    ST_RREC  = 3'd2,
    ST_WR    = 3'd3,
    ST_WHOLD = 3'd4
  } sram_st_e;

  // Clock cycles needed to cover a limit in ns, never fewer than one.
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int rd_cycles(input int period, input int t_rc, input int t_aa, input int t_oe);
    return imax(imax(ns_to_cyc(t_rc, period), ns_to_cyc(t_aa, period)), ns_to_cyc(t_oe, period));
  endfunction

  // Chip select stays low one extra cycle after write enable rises, so the
  // cycle-time term is reduced by one.
  function automatic int wr_cycles(input int period, input int t_wp, input int t_dw,
                                   input int t_aw, input int t_wc);
    return imax(imax(ns_to_cyc(t_wp, period), ns_to_cyc(t_dw, period)),
                imax(ns_to_cyc(t_aw, period), ns_to_cyc(t_wc, period) - 1));
  endfunction

endpackage

// File: rtl/sram_phase_cnt.sv
`timescale 1ns/1ps
module sram_phase_cnt #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/sram_dq_path.sv
`timescale 1ns/1ps
module sram_dq_path #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_start,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              drive_nxt,
  input  logic              capture,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sram_addr   <= '0;
      sram_dq_out <= '0;
      sram_dq_oe  <= 1'b0;
      rdata       <= '0;
    end else begin
      if (acc_start) begin
        sram_addr   <= req_addr;
        sram_dq_out <= req_wdata;
      end
      sram_dq_oe <= drive_nxt;
      if (capture) rdata <= sram_dq_in;
    end
  end
endmodule

// File: rtl/sram_ctrl.sv
`timescale 1ns/1ps
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 19,
  parameter int DATA_W        = 8,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 25,
  parameter int T_WC_NS       = 55,
  parameter int T_WP_NS       = 35,
  parameter int T_DW_NS       = 25,
  parameter int T_AW_NS       = 40,
  parameter int T_HZ_NS       = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in,
  output logic              sram_cs_n,
  output logic              sram_we_n,
  output logic              sram_oe_n
);
  localparam int RD_CYC  = rd_cycles(CLK_PERIOD_NS, T_RC_NS, T_AA_NS, T_OE_NS);
  localparam int WR_CYC  = wr_cycles(CLK_PERIOD_NS, T_WP_NS, T_DW_NS, T_AW_NS, T_WC_NS);
  localparam int HZ_CYC  = ns_to_cyc(T_HZ_NS, CLK_PERIOD_NS);
  localparam int CYC_MIN = ns_to_cyc(imax(T_RC_NS, T_WC_NS), CLK_PERIOD_NS);
  localparam int CNT_W   = $clog2(imax(imax(RD_CYC, WR_CYC), HZ_CYC) + 1);

  sram_st_e st_q, st_nxt;
  logic             ph_load, ph_done, acc_start, rd_capture, ack_nxt, drive_nxt;
  logic [CNT_W-1:0] ph_val;

  // Named events for the bound checker.
  logic st_idle;
  assign st_idle = (st_q == ST_IDLE);

  sram_phase_cnt #(.CNT_W(CNT_W)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load), .load_val(ph_val), .expired(ph_done)
  );

  always_comb begin
    st_nxt     = st_q;
    ph_load    = 1'b0;
    ph_val     = '0;
    acc_start  = 1'b0;
    rd_capture = 1'b0;
    ack_nxt    = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req) begin
        acc_start = 1'b1;
        ph_load   = 1'b1;
        if (req_we) begin
          st_nxt = ST_WR;
          ph_val = CNT_W'(WR_CYC - 1);
        end else begin
          st_nxt = ST_RD;
          ph_val = CNT_W'(RD_CYC - 1);
        end
      end
      ST_RD: if (ph_done) begin
        rd_capture = 1'b1;
        ack_nxt    = 1'b1;
        ph_load    = 1'b1;
        ph_val     = CNT_W'(HZ_CYC - 1);
        st_nxt     = ST_RREC;
      end
      ST_RREC:  if (ph_done) st_nxt = ST_IDLE;
      ST_WR:    if (ph_done) st_nxt = ST_WHOLD;
      ST_WHOLD: begin
        ack_nxt = 1'b1;
        st_nxt  = ST_IDLE;
      end
      default:  st_nxt = ST_IDLE;
    endcase
  end

  assign drive_nxt = (st_nxt == ST_WR) || (st_nxt == ST_WHOLD);

  // Pin strobes are decoded from the next state so they leave flops directly.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sram_cs_n <= 1'b1;
      sram_we_n <= 1'b1;
      sram_oe_n <= 1'b1;
      ack       <= 1'b0;
    end else begin
      st_q      <= st_nxt;
      sram_cs_n <= !((st_nxt == ST_RD) || drive_nxt);
      sram_we_n <= (st_nxt != ST_WR);
      sram_oe_n <= (st_nxt != ST_RD);
      ack       <= ack_nxt;
    end
  end

  sram_dq_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dq (
    .clk(clk), .rst_n(rst_n), .acc_start(acc_start), .req_addr(req_addr),
    .req_wdata(req_wdata), .drive_nxt(drive_nxt), .capture(rd_capture),
    .sram_dq_in(sram_dq_in), .sram_addr(sram_addr), .sram_dq_out(sram_dq_out),
    .sram_dq_oe(sram_dq_oe), .rdata(rdata)
  );
endmodule

// File: rtl/sram_ctrl_chk.sv
`timescale 1ns/1ps
module sram_ctrl_chk #(
  parameter int ADDR_W  = 19,
  parameter int WR_CYC  = 5,
  parameter int HZ_CYC  = 2,
  parameter int CYC_MIN = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ack,
  input logic              sram_cs_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_dq_oe,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              st_idle,
  input logic              rd_capture
);
  logic [7:0] we_lo_cnt, cs_lo_cnt, oe_hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_lo_cnt <= '0;
      cs_lo_cnt <= '0;
      oe_hi_cnt <= 8'hFF;
    end else begin
      we_lo_cnt <= sram_we_n ? 8'd0 : ((we_lo_cnt == 8'hFF) ? we_lo_cnt : we_lo_cnt + 8'd1);
      cs_lo_cnt <= sram_cs_n ? 8'd0 : ((cs_lo_cnt == 8'hFF) ? cs_lo_cnt : cs_lo_cnt + 8'd1);
      oe_hi_cnt <= !sram_oe_n ? 8'd0 : ((oe_hi_cnt == 8'hFF) ? oe_hi_cnt : oe_hi_cnt + 8'd1);
    end
  end

  p_idle_standby_r1: assert property (@(posedge clk) disable iff (!rst_n)
    st_idle |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));

  p_read_strobes_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> (!sram_cs_n && sram_we_n && !sram_dq_oe));

  p_capture_in_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |-> (!sram_oe_n && !sram_cs_n));

  p_capture_acks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_capture |=> ack);

  p_we_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_lo_cnt >= 8'(WR_CYC)));

  p_we_inside_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (!sram_cs_n && sram_dq_oe && sram_oe_n));

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sram_dq_oe |-> sram_oe_n);

  p_turnaround_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_dq_oe) |-> (oe_hi_cnt >= 8'(HZ_CYC)));

  p_addr_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_cs_n && $past(!sram_cs_n)) |-> $stable(sram_addr));

  p_ack_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);

  p_cycle_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_cs_n) |-> (cs_lo_cnt >= 8'(CYC_MIN)));

  p_ack_standby_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe));
endmodule

bind sram_ctrl sram_ctrl_chk #(
  .ADDR_W(ADDR_W), .WR_CYC(WR_CYC), .HZ_CYC(HZ_CYC), .CYC_MIN(CYC_MIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ack(ack), .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n),
  .sram_oe_n(sram_oe_n), .sram_dq_oe(sram_dq_oe), .sram_addr(sram_addr),
  .st_idle(st_idle), .rd_capture(rd_capture)
);

// File: tb/test_sram_ctrl.sv
`timescale 1ns/1ps
module test_sram_ctrl;
  localparam int P = 10;

  function automatic int cyc(input int ns);
    int c;
    c = ns / P + ((ns % P) != 0 ? 1 : 0);
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int RD_E  = mx(mx(cyc(55), cyc(55)), cyc(25));
  localparam int WR_E  = mx(mx(mx(cyc(35), cyc(25)), cyc(40)), mx(cyc(55) - 1, 1));
  localparam int HZ_E  = cyc(20);
  localparam int CYC_E = cyc(55);

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic ack, sram_dq_oe, sram_cs_n, sram_we_n, sram_oe_n;
  logic [7:0]  rdata, sram_dq_out;
  logic [7:0]  sram_dq_in = 8'h00;
  logic [18:0] sram_addr;

  always #5 clk = ~clk;

  sram_ctrl i_sram_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .ack(ack), .rdata(rdata), .sram_addr(sram_addr),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n)
  );

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [7:0] mem [logic [18:0]];
  logic [7:0] shadow [logic [18:0]];
  realtime t_acc = 0, t_rel = -1000, t_oef = 0, t_wef = 0, t_csf = 0, t_adr = 0, t_dq = 0;
  bit rd_prev = 1'b0;
  logic [18:0] adr_prev = '0;

  always @(sram_cs_n or sram_oe_n or sram_we_n or sram_addr) begin
    bit rd_now;
    rd_now = !sram_cs_n && !sram_oe_n && sram_we_n;
    if (rd_now && (!rd_prev || sram_addr != adr_prev)) t_acc = $realtime;
    if (!rd_now && rd_prev) t_rel = $realtime;
    rd_prev  = rd_now;
    adr_prev = sram_addr;
  end
  always @(negedge sram_oe_n) t_oef = $realtime;
  always @(negedge sram_we_n) t_wef = $realtime;
  always @(negedge sram_cs_n) t_csf = $realtime;
  always @(sram_addr) t_adr = $realtime;
  always @(sram_dq_out or sram_dq_oe) t_dq = $realtime;

  // Write latched on write-enable rise while chip select is low (R10).
  always @(posedge sram_we_n) if (!sram_cs_n) begin
    check(($realtime - t_wef) >= 35.0, "R10 we pulse ns", int'($realtime - t_wef), 35);
    check(($realtime - t_dq) >= 25.0 && sram_dq_oe, "R10 data setup ns", int'($realtime - t_dq), 25);
    check(($realtime - t_csf) >= 40.0, "R10 cs before write end ns", int'($realtime - t_csf), 40);
    check(($realtime - t_adr) >= 40.0, "R10 addr before write end ns", int'($realtime - t_adr), 40);
    mem[sram_addr] = sram_dq_out;
  end

  int contention = 0, addr_moves = 0, oe_hi = 100;
  bit cs_prev = 1'b1, oe_drv_prev = 1'b0;
  logic [18:0] a_prev = '0;

  always @(negedge clk) begin
    bit rd_now, mem_drv;
    logic [7:0] v;
    rd_now  = !sram_cs_n && !sram_oe_n && sram_we_n;
    mem_drv = rd_now || (($realtime - t_rel) < 20.0);
    if (mem_drv && sram_dq_oe) contention++;
    v = mem.exists(sram_addr) ? mem[sram_addr] : 8'h00;
    if (rd_now) sram_dq_in <= (($realtime - t_acc) >= 55.0 && ($realtime - t_oef) >= 25.0) ? v : ~v;
    else sram_dq_in <= 8'h5A;
    if (rst_n && !sram_cs_n && !cs_prev && sram_addr != a_prev) addr_moves++;
    // R5: drivers turn on only after output enable has been high long enough
    if (rst_n && sram_dq_oe && !oe_drv_prev)
      check(oe_hi >= HZ_E, "R5 oe_n high cycles before drive", oe_hi, HZ_E);
    oe_hi       = sram_oe_n ? oe_hi + 1 : 0;
    oe_drv_prev = sram_dq_oe;
    cs_prev     = sram_cs_n;
    a_prev      = sram_addr;
  end

  // ---------------- access driver ----------------
  task automatic run_access(input bit wr, input logic [18:0] a, input logic [7:0] d,
                            input bit disturb, output logic [7:0] q, output int lat,
                            output int cs_lo, output int we_lo, output int oe_lo,
                            output bit strobe_ok, output bit stand_ok);
    @(negedge clk);
    req = 1'b1; req_we = wr; req_addr = a; req_wdata = d;
    lat = 0; cs_lo = 0; we_lo = 0; oe_lo = 0; strobe_ok = 1'b1; stand_ok = 1'b0; q = '0;
    forever begin
      @(negedge clk);
      lat++;
      if (ack) begin
        q = rdata;
        stand_ok = sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe;
        req = 1'b0;
        break;
      end
      if (!sram_cs_n) cs_lo++;
      if (!sram_we_n) we_lo++;
      if (!sram_oe_n) oe_lo++;
      if (!sram_cs_n) begin
        if (sram_addr != a) strobe_ok = 1'b0;
        if (wr) begin
          if (!sram_oe_n || !sram_dq_oe || sram_dq_out != d) strobe_ok = 1'b0;
        end else if (!sram_we_n || sram_oe_n || sram_dq_oe) strobe_ok = 1'b0;
      end
      if (disturb && lat == 2) begin
        req_we = !wr; req_addr = ~a; req_wdata = ~d;
      end
      if (lat > 60) begin
        check(1'b0, "R7 ack timeout", lat, 0);
        req = 1'b0;
        break;
      end
    end
    @(negedge clk);
    check(!ack, "R7 ack lasts one cycle", ack, 0);
  endtask

  task automatic t_write(input logic [18:0] a, input logic [7:0] d, input bit disturb);
    logic [7:0] q; int lat, cs_lo, we_lo, oe_lo; bit s_ok, sb_ok;
    run_access(1'b1, a, d, disturb, q, lat, cs_lo, we_lo, oe_lo, s_ok, sb_ok);
    shadow[a] = d;
    check(we_lo == WR_E, "R4 we_n low cycles", we_lo, WR_E);
    check(cs_lo == WR_E + 1, "R4 cs_n low cycles", cs_lo, WR_E + 1);
    check(cs_lo >= CYC_E, "R8 write cycle length", cs_lo, CYC_E);
    check(s_ok, disturb ? "R7 write ignores mid-access changes" : "R4 write strobes/data", s_ok, 1);
    check(lat == WR_E + 2, "R4 write ack latency", lat, WR_E + 2);
    check(sb_ok, "R9 standby at ack (write)", sb_ok, 1);
  endtask

  task automatic t_read(input logic [18:0] a, input bit disturb);
    logic [7:0] q; int lat, cs_lo, we_lo, oe_lo; bit s_ok, sb_ok;
    run_access(1'b0, a, 8'h00, disturb, q, lat, cs_lo, we_lo, oe_lo, s_ok, sb_ok);
    check(oe_lo == RD_E && cs_lo == RD_E, "R2 read strobe cycles", oe_lo, RD_E);
    check(cs_lo >= CYC_E, "R8 read cycle length", cs_lo, CYC_E);
    check(s_ok, disturb ? "R7 read ignores mid-access changes" : "R2 read strobes/address", s_ok, 1);
    check(lat == RD_E + 1, "R3 read ack latency", lat, RD_E + 1);
    check(sb_ok, "R9 standby at ack (read)", sb_ok, 1);
    check(q == shadow[a], "R3 R10 read data", q, shadow[a]);
  endtask

  task automatic t_reset_state;
    check(sram_cs_n && sram_we_n && sram_oe_n, "R1 strobes high in reset",
          {sram_cs_n, sram_we_n, sram_oe_n}, 3'b111);
    check(!sram_dq_oe && !ack, "R1 drivers off and no ack in reset", {sram_dq_oe, ack}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sram_cs_n && sram_we_n && sram_oe_n && !sram_dq_oe && !ack, "R1 idle after reset",
          {sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe, ack}, 5'b11100);
  endtask

  task automatic t_boundaries;
    t_write(19'h00000, 8'h3C, 1'b0);
    t_write(19'h7FFFF, 8'hC3, 1'b0);
    t_read(19'h00000, 1'b0);
    t_read(19'h7FFFF, 1'b0);
  endtask

  task automatic t_turnaround;   // read immediately followed by write, then back
    t_write(19'h12345, 8'hA5, 1'b0);
    t_read(19'h12345, 1'b0);
    t_write(19'h12346, 8'h5A, 1'b0);
    t_read(19'h12346, 1'b0);
    t_write(19'h12345, 8'h0F, 1'b0);   // overwrite
    t_read(19'h12345, 1'b0);
  endtask

  task automatic t_busy_ignore;
    t_write(19'h00ABC, 8'h77, 1'b1);
    t_read(19'h00ABC, 1'b1);
    repeat (4) @(negedge clk);
    check(sram_cs_n && !ack, "R7 no extra access after disturbed request",
          {sram_cs_n, ack}, 2'b10);
  endtask

  task automatic t_random;
    logic [18:0] adrs [8];
    foreach (adrs[i]) begin
      adrs[i] = 19'($urandom) ^ 19'(i << 16);
      t_write(adrs[i], 8'($urandom), 1'b0);
    end
    foreach (adrs[i]) t_read(adrs[i], 1'b0);
  endtask

  task automatic finish_run;
    check(contention == 0, "R5 bus contention cycles", contention, 0);
    check(addr_moves == 0, "R6 address moves under chip select", addr_moves, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    t_boundaries();
    t_turnaround();
    t_busy_ignore();
    t_random();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      check(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule